// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Indexed Enables

This block collects a parameterized set of level-sensitive interrupt inputs and delivers a single interrupt line to one processor. Every source has its own enable, its own per-processor mask and a 4-bit priority. The processor has a task-priority threshold. A source takes part in arbitration only when its input is high, it is enabled, it is unmasked, and its priority is strictly above the threshold. Software reads an acknowledge register to get the identity of the winning source. When no source qualifies, that read returns the spurious code 1023.

Software reaches the block through a simple 32-bit register bus with separate read and write strobes. Address bit 12 selects the region: 0 selects the shared (global) region and 1 selects the per-processor region. Enables and masks are changed by writing a source number to dedicated set and clear registers, so no read-modify-write of a bitmap is needed. A small doorbell cause register latches event pulses from elsewhere in the chip. Software clears it with a write.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all enables are clear, all masks are set, all priorities and the threshold are 0, and priority selection is off. The interrupt output is low, an acknowledge read returns 1023, and the global control word at offset 0x000 reads NUM_SRC in bits 11:2 with bit 0 clear.
- R2: In the global region, writing a source number to offset 0x030 sets that source's enable, and writing a source number to offset 0x034 clears it. The enable is visible in bit 28 of the source's control word.
- R3: The source control word at global offset 0x100 + 4×n holds the priority in bits 27:24 and the enable in bit 28. Both fields can be written and read back.
- R4: In the per-processor region, writing a source number to offset 0x048 masks that source, and writing a source number to offset 0x04c unmasks it. A masked source is never delivered.
- R5: The threshold is held in bits 31:28 of per-processor offset 0x040. A source qualifies only if its priority is strictly greater than the threshold.
- R6: When bit 0 of the global control word is 1, the qualifying source with the highest priority wins. A tie goes to the lowest source number.
- R7: When bit 0 of the global control word is 0, the qualifying source with the lowest number wins, whatever the priorities.
- R8: A read of per-processor offset 0x044 returns the winner's number in bits 9:0, or 1023 if no source qualifies. The read does not clear anything, and a source stays pending until its input falls.
- R9: The interrupt output is a register. It goes high one clock after at least one source qualifies and falls one clock after none does.
- R10: An index write (offsets 0x030, 0x034, 0x048, 0x04c) with a value of NUM_SRC or more is ignored.
- R11: Each cycle, a doorbell input pulse sets the matching bit of the cause register at per-processor offset 0x008. A write to that offset keeps only the cause bits whose write-data bit is 1, so writing 0 clears all of them. A pulse arriving in the same cycle as a write still sets its bit.
- R12: Read data appears on the read-data port one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| db_i | input | DB_W | Doorbell event pulses |
| bus_addr | input | 13 | Byte address; bit 12 selects the per-processor region |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 32 and DB_W = 4. With 32 sources, index 31 is the last valid source and index 32 is the first value that must be ignored. A design that truncated the index to five bits would map 32 onto source 0, and the bench would catch it. Four doorbell bits allow a write with a partial pattern to be told apart from a clear-all write. The bench builds ties between equal priorities, thresholds that sit exactly at a source's priority, and cases where the two selection modes choose different winners.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int ADDR_W   = 13;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 4;
  localparam logic [ID_W-1:0] NO_SRC_ID = 10'd1023;

  // global region offsets
  localparam logic [11:0] G_CTRL   = 12'h000;
  localparam logic [11:0] G_EN_SET = 12'h030;
  localparam logic [11:0] G_EN_CLR = 12'h034;
  // per-processor region offsets
  localparam logic [11:0] C_DBELL  = 12'h008;
  localparam logic [11:0] C_THRESH = 12'h040;
  localparam logic [11:0] C_ACK    = 12'h044;
  localparam logic [11:0] C_MK_SET = 12'h048;
  localparam logic [11:0] C_MK_CLR = 12'h04c;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_set_we,
  input  logic                             en_clr_we,
  input  logic                             mk_set_we,
  input  logic                             mk_clr_we,
  input  logic                             cfg_we,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [31:0]                      wdata,
  output logic [NUM_SRC-1:0]               en_q,
  output logic [NUM_SRC-1:0]               mask_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q
);
  logic idx_ok;
  assign idx_ok = (wdata < 32'(NUM_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '1;
      prio_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (idx_ok && wdata == 32'(i)) begin
          if (en_set_we) en_q[i]   <= 1'b1;
          if (en_clr_we) en_q[i]   <= 1'b0;
          if (mk_set_we) mask_q[i] <= 1'b1;
          if (mk_clr_we) mask_q[i] <= 1'b0;
        end
        if (cfg_we && int'(cfg_idx) == i) begin
          prio_q[i] <= wdata[27:24];
          en_q[i]   <= wdata[28];
        end
      end
    end
  end

  AST_OOR_EN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((en_set_we || en_clr_we) && !idx_ok && !cfg_we) |=> $stable(en_q)) else $error("enable changed by out-of-range index"); // R10
  AST_OOR_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((mk_set_we || mk_clr_we) && !idx_ok) |=> $stable(mask_q)) else $error("mask changed by out-of-range index"); // R10
  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q && en_q == '0)) else $error("bad reset state"); // R1
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                           prio_mode,
  output logic                           win_valid,
  output logic [ID_W-1:0]                win_id
);
  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    win_valid = 1'b0;
    win_id    = NO_SRC_ID;
    best_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid || (prio_mode && prio[i] > best_prio))) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_doorbell.sv
module irq_doorbell #(
  parameter int DB_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DB_W-1:0] db_i,
  input  logic            keep_we,
  input  logic [DB_W-1:0] keep_bits,
  output logic [DB_W-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= (keep_we ? (cause_q & keep_bits) : cause_q) | db_i;
  end

  AST_DB_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    (keep_we && keep_bits == '0) |=> (cause_q == $past(db_i))) else $error("doorbell clear failed"); // R11
  AST_DB_STICKY: assert property (@(posedge clk) disable iff (rst)
    !keep_we |=> ((cause_q & $past(cause_q)) == $past(cause_q))) else $error("doorbell bit lost"); // R11
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DB_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [DB_W-1:0]     db_i,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_o
);
  localparam int IDX_W = 6;
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]             en_q, mask_q, elig;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [DB_W-1:0]                cause_q;
  logic                           prio_mode_q;
  logic [PRIO_W-1:0]              thresh_q;
  logic                           win_valid;
  logic [ID_W-1:0]                win_id;

  logic        in_cpu;
  logic [11:0] off;
  logic [IDX_W-1:0] cfg_idx;
  logic        cfg_hit;
  logic        g_wr, c_wr;

  assign in_cpu  = bus_addr[12];
  assign off     = bus_addr[11:0];
  assign cfg_idx = off[7:2];
  assign cfg_hit = (off[11:8] == 4'h1) && (off[1:0] == 2'b00) && (int'(cfg_idx) < NUM_SRC);
  assign g_wr    = bus_wr && !in_cpu;
  assign c_wr    = bus_wr && in_cpu;

  irq_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .en_set_we (g_wr && off == G_EN_SET),
    .en_clr_we (g_wr && off == G_EN_CLR),
    .mk_set_we (c_wr && off == C_MK_SET),
    .mk_clr_we (c_wr && off == C_MK_CLR),
    .cfg_we    (g_wr && cfg_hit),
    .cfg_idx   (cfg_idx),
    .wdata     (bus_wdata),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .prio_q    (prio_q)
  );

  irq_doorbell #(.DB_W(DB_W)) u_dbell (
    .clk       (clk),
    .rst       (rst),
    .db_i      (db_i),
    .keep_we   (c_wr && off == C_DBELL),
    .keep_bits (bus_wdata[DB_W-1:0]),
    .cause_q   (cause_q)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig[g] = src_i[g] && en_q[g] && !mask_q[g] && (prio_q[g] > thresh_q);
    end
  endgenerate

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .elig      (elig),
    .prio      (prio_q),
    .prio_mode (prio_mode_q),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_mode_q <= 1'b0;
      thresh_q    <= '0;
      irq_o       <= 1'b0;
    end else begin
      irq_o <= win_valid;
      if (g_wr && off == G_CTRL)   prio_mode_q <= bus_wdata[0];
      if (c_wr && off == C_THRESH) thresh_q    <= bus_wdata[31:28];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (!in_cpu) begin
        if (off == G_CTRL)
          bus_rdata <= {20'd0, 10'(NUM_SRC), 1'b0, prio_mode_q};
        else if (cfg_hit)
          bus_rdata <= {3'd0, en_q[cfg_idx[SEL_W-1:0]], prio_q[cfg_idx[SEL_W-1:0]], 24'd0};
      end else begin
        case (off)
          C_DBELL:  bus_rdata <= 32'(cause_q);
          C_THRESH: bus_rdata <= {thresh_q, 28'd0};
          C_ACK:    bus_rdata <= {22'd0, win_id};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  // independent view for checking: highest qualifying priority
  logic [PRIO_W-1:0] top_prio;
  logic [ID_W-1:0]   low_id;
  always_comb begin
    top_prio = '0;
    low_id   = NO_SRC_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) low_id = ID_W'(i);
      if (elig[i] && prio_q[i] > top_prio) top_prio = prio_q[i];
    end
  end

  AST_WIN_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> elig[win_id[SEL_W-1:0]]) else $error("winner not eligible"); // R5
  AST_WIN_TOP_PRIO: assert property (@(posedge clk) disable iff (rst)
    (win_valid && prio_mode_q) |-> (prio_q[win_id[SEL_W-1:0]] == top_prio)) else $error("winner not top priority"); // R6
  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !prio_mode_q) |-> (win_id == low_id)) else $error("winner not lowest index"); // R7
  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |-> (win_id == NO_SRC_ID)) else $error("no spurious code"); // R8
  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(elig != '0))) else $error("irq timing"); // R9
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int NS = 32;
  localparam int DW = 4;
  localparam logic [12:0] G = 13'h0000;
  localparam logic [12:0] C = 13'h1000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   src_i = '0;
  logic [DW-1:0]   db_i = '0;
  logic [12:0]     bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_o;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NS), .DB_W(DW)) u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .db_i(db_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // R12: read data is compared one clock after the strobe
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          errors++;
          $display("FAIL %s read: actual %h expected %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, input logic [31:0] expv, input string tag);
    exp_t e;
    @(negedge clk);
    e.val = expv; e.tag = tag;
    exp_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_irq(input logic expv, input string tag);
    @(negedge clk);
    checks++;
    if (irq_o !== expv) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq_o, expv);
    end
  endtask

  function automatic logic [31:0] cfgw(input int en, input int pr);
    return {3'd0, 1'(en), 4'(pr), 24'd0};
  endfunction

  function automatic logic [12:0] cfga(input int n);
    return G + 13'h100 + 13'(4 * n);
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        checks++;
        if (irq_o !== 1'b0) begin errors++; $display("FAIL R1 irq: actual %b expected 0", irq_o); end
        bus_read(G, 32'h80, "R1");
        bus_read(C + 13'h044, 32'd1023, "R1");
        bus_read(cfga(5), 32'h0, "R1");
        bus_read(C + 13'h008, 32'h0, "R1");

        bus_write(G, 32'h1);
        bus_read(G, 32'h81, "R6");

        // R3 field readback
        bus_write(cfga(3), cfgw(0, 5));
        bus_read(cfga(3), 32'h0500_0000, "R3");
        // R2 set enable
        bus_write(G + 13'h030, 32'd3);
        bus_read(cfga(3), 32'h1500_0000, "R2");

        // R4 masked from reset
        @(negedge clk) src_i[3] = 1'b1;
        check_irq(1'b0, "R4");
        bus_write(C + 13'h04c, 32'd3);
        // R9 registered one cycle later
        checks++;
        if (irq_o !== 1'b0) begin errors++; $display("FAIL R9 irq early: actual %b expected 0", irq_o); end
        check_irq(1'b1, "R9");
        bus_read(C + 13'h044, 32'd3, "R8");
        bus_read(C + 13'h044, 32'd3, "R8");

        // R5 threshold equal blocks, lower passes
        bus_write(C + 13'h040, 32'h5000_0000);
        check_irq(1'b0, "R5");
        bus_read(C + 13'h044, 32'd1023, "R5");
        bus_read(C + 13'h040, 32'h5000_0000, "R5");
        bus_write(C + 13'h040, 32'h4000_0000);
        check_irq(1'b1, "R5");

        // R6 highest priority, tie to lowest index
        bus_write(cfga(7), cfgw(1, 9));
        bus_write(C + 13'h04c, 32'd7);
        @(negedge clk) src_i[7] = 1'b1;
        bus_read(C + 13'h044, 32'd7, "R6");
        bus_write(cfga(2), cfgw(1, 9));
        bus_write(C + 13'h04c, 32'd2);
        @(negedge clk) src_i[2] = 1'b1;
        bus_read(C + 13'h044, 32'd2, "R6");

        // R7 lowest index in plain mode
        bus_write(C + 13'h040, 32'h0);
        bus_write(cfga(2), cfgw(1, 1));
        bus_read(C + 13'h044, 32'd7, "R6");
        bus_write(G, 32'h0);
        bus_read(C + 13'h044, 32'd2, "R7");
        bus_write(G, 32'h1);

        // R2 clear enable
        bus_write(G + 13'h034, 32'd7);
        bus_read(cfga(7), 32'h0900_0000, "R2");
        bus_read(C + 13'h044, 32'd3, "R2");
        // R4 set mask
        bus_write(C + 13'h048, 32'd3);
        bus_read(C + 13'h044, 32'd2, "R4");

        // R10 out-of-range index writes
        bus_write(G + 13'h030, 32'd32);
        bus_read(cfga(0), 32'h0, "R10");
        bus_write(cfga(0), cfgw(1, 15));
        @(negedge clk) src_i[0] = 1'b1;
        bus_write(C + 13'h04c, 32'd32);
        bus_read(C + 13'h044, 32'd2, "R10");
        bus_write(G + 13'h034, 32'h20);
        bus_read(cfga(0), 32'h1F00_0000, "R10");

        // R8 level sensitive: pending until input falls
        bus_write(C + 13'h048, 32'd0);
        bus_read(C + 13'h044, 32'd2, "R8");
        @(negedge clk) src_i[2] = 1'b0;
        check_irq(1'b0, "R8");
        bus_read(C + 13'h044, 32'd1023, "R8");

        // R11 doorbell
        @(negedge clk) db_i = 4'b1010;
        @(negedge clk) db_i = 4'b0000;
        bus_read(C + 13'h008, 32'hA, "R11");
        bus_write(C + 13'h008, 32'h8);
        bus_read(C + 13'h008, 32'h8, "R11");
        bus_write(C + 13'h008, 32'h0);
        bus_read(C + 13'h008, 32'h0, "R11");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
          errors++;
          $display("FAIL R12 missing read data: actual %0d pending expected 0", exp_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule